// File: doc/BRIEF.md
# Thread Fetch Status Controller

This block tracks the fetch status of one hardware thread in an out-of-order pipeline front end. Each cycle it takes block and unblock pulses from four downstream stages, a context-switch flag, redirect requests from commit and from decode (each with its own target PC), and a flag that says the reorder buffer is still flushing. From these it decides whether the thread runs, stalls, squashes or keeps waiting. It also drives the instruction cache handshake: it presents a request, parks a refused request for retry, matches returning responses by a small request tag, and drops any response that no longer belongs to the live request.

The status is exposed as a 4-bit code, and the current fetch PC is a register that only a redirect changes. The retry slot is held inside the block as one cache-blocked flag, which suits a single fetching thread. A translation fault parks the thread in a trap state until a redirect arrives.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After reset the status code is 0 (running), the fetch PC equals the RESET_PC parameter, no request is presented and the cache-blocked flag is 0. The status codes are: 0 running, 1 idle, 2 squashing, 3 blocked, 4 waiting for response, 5 waiting for retry, 6 access complete, 7 trap pending, 8 quiesce pending.
- R2: Each of the four stall sources is set by its block pulse and cleared by its unblock pulse. The thread counts as stalled when any source is set or the context-switch input is high. A stalled thread in running, squashing, blocked or access complete moves to blocked (3). A blocked thread with no stall returns to running (0) on the next cycle.
- R3: A commit redirect takes priority over every other input. In the next cycle the status is squashing (2) and the PC holds the commit target. A squashing thread with no new input returns to running.
- R4: While the reorder-buffer flush flag is high, the thread moves to squashing and the PC keeps its value.
- R5: A decode redirect moves the thread to squashing and loads the decode target. When the thread is already squashing, the decode redirect is ignored and the PC is unchanged.
- R6: A stall does not move a thread out of waiting for response (4).
- R7: A fetch attempt in running, with no fault, presents a request whose tag comes from a counter. The counter starts at 0 and advances by one per new request, accepted or refused. If the cache accepts the request, the status becomes 4.
- R8: A response whose tag matches the outstanding request, while in state 4, moves the thread to access complete (6), or to blocked (3) if it is stalled. A fetch attempt in state 6 returns the thread to running.
- R9: A response that arrives outside state 4, or whose tag does not match, raises the drop output in that cycle and leaves the status unchanged.
- R10: A refused request moves the thread to waiting for retry (5) and sets the cache-blocked flag. In state 5 the request is presented again every cycle with the same tag. Once it is accepted, the status becomes 4 and the flag clears.
- R11: A fault on a fetch attempt moves the thread to trap pending (7). Stalls and fetch attempts do not move it out; only a redirect does.
- R12: A redirect abandons any outstanding request: a later response carrying the old tag is dropped. A redirect also cancels a parked retry and clears the cache-blocked flag.
- R13: When a redirect and a matching response arrive in the same cycle, the redirect wins and the response is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| blockIn | input | NSRC | Per-stage block pulses |
| unblockIn | input | NSRC | Per-stage unblock pulses |
| ctxSwitch | input | 1 | Context switch in progress (stall) |
| commitSquash | input | 1 | Redirect from commit |
| commitPc | input | PCW | Commit redirect target |
| robSquashing | input | 1 | Reorder buffer still flushing |
| decodeSquash | input | 1 | Redirect from decode |
| decodePc | input | PCW | Decode redirect target |
| fetchAttempt | input | 1 | Fetch wants to access the cache this cycle |
| faultIn | input | 1 | Translation fault on this attempt |
| reqReady | input | 1 | Cache accepts the presented request |
| respValid | input | 1 | Cache response valid |
| respId | input | IDW | Tag of the response |
| status | output | 4 | Encoded thread status |
| pcOut | output | PCW | Current fetch PC |
| reqValid | output | 1 | Request presented to the cache |
| reqId | output | IDW | Tag of the presented request |
| dropResp | output | 1 | Response discarded as stale |
| cacheBlocked | output | 1 | Retry slot occupied |

## Verification
Two functions can fall in the same cycle: a redirect, and a response whose tag matches the live request. The bench sets up that collision by issuing a request, then raising a commit redirect and the matching response in one cycle. It judges the result by the drop output in that cycle and by the squashing status and new PC in the next one. A second overlap, commit and decode redirects arriving together, is judged by which target lands in the PC.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  typedef enum logic [3:0] {
    ST_RUN       = 4'd0,
    ST_IDLE      = 4'd1,
    ST_SQUASH    = 4'd2,
    ST_BLOCKED   = 4'd3,
    ST_WAIT_RESP = 4'd4,
    ST_WAIT_RTRY = 4'd5,
    ST_ACC_DONE  = 4'd6,
    ST_TRAP      = 4'd7,
    ST_QUIESCE   = 4'd8
  } fetchState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadCommitPc;
    logic loadDecodePc;
    logic issueNew;
    logic parkRetry;
    logic clearBlock;
  } fscStrobe_t;

endpackage

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
  import fsc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        commitSquash,
  input  logic        robSquashing,
  input  logic        decodeSquash,
  input  logic        stalled,
  input  logic        fetchAttempt,
  input  logic        faultIn,
  input  logic        reqReady,
  input  logic        respValid,
  input  logic        idMatch,
  output fetchState_e state,
  output fscStrobe_t  strobe,
  output logic        reqValid,
  output logic        respTake
);

  fetchState_e nextState;
  logic stallable;

  assign stallable = (state == ST_RUN) || (state == ST_SQUASH) ||
                     (state == ST_BLOCKED) || (state == ST_ACC_DONE);

  always_comb begin
    nextState = state;
    strobe    = '0;
    reqValid  = 1'b0;
    respTake  = 1'b0;
    if (commitSquash) begin
      nextState = ST_SQUASH;
      strobe.loadCommitPc = 1'b1;
      strobe.clearBlock   = 1'b1;
    end else if (robSquashing) begin
      nextState = ST_SQUASH;
      strobe.clearBlock = 1'b1;
    end else if (decodeSquash && state != ST_SQUASH) begin
      nextState = ST_SQUASH;
      strobe.loadDecodePc = 1'b1;
      strobe.clearBlock   = 1'b1;
    end else if (stalled && stallable) begin
      nextState = ST_BLOCKED;
    end else if (state == ST_BLOCKED || state == ST_SQUASH) begin
      nextState = ST_RUN;
    end else begin
      case (state)
        ST_RUN: begin
          if (fetchAttempt) begin
            if (faultIn) begin
              nextState = ST_TRAP;
            end else begin
              reqValid        = 1'b1;
              strobe.issueNew = 1'b1;
              if (reqReady) begin
                nextState = ST_WAIT_RESP;
              end else begin
                nextState        = ST_WAIT_RTRY;
                strobe.parkRetry = 1'b1;
              end
            end
          end
        end
        ST_WAIT_RTRY: begin
          reqValid = 1'b1;
          if (reqReady) begin
            nextState         = ST_WAIT_RESP;
            strobe.clearBlock = 1'b1;
          end
        end
        ST_WAIT_RESP: begin
          if (respValid && idMatch) begin
            respTake  = 1'b1;
            nextState = stalled ? ST_BLOCKED : ST_ACC_DONE;
          end
        end
        ST_ACC_DONE: begin
          if (fetchAttempt) nextState = ST_RUN;
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

endmodule

// File: rtl/fsc_datapath.sv
module fsc_datapath
  import fsc_pkg::*;
#(
  parameter int PCW      = 32,
  parameter int IDW      = 3,
  parameter int NSRC     = 4,
  parameter logic [PCW-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  fscStrobe_t      strobe,
  input  logic [NSRC-1:0] blockIn,
  input  logic [NSRC-1:0] unblockIn,
  input  logic            ctxSwitch,
  input  logic [PCW-1:0]  commitPc,
  input  logic [PCW-1:0]  decodePc,
  input  logic [IDW-1:0]  respId,
  output logic            stalled,
  output logic            idMatch,
  output logic [PCW-1:0]  pcOut,
  output logic [IDW-1:0]  reqId,
  output logic            cacheBlocked
);

  logic [NSRC-1:0] stallReg, stallNext;
  logic [IDW-1:0]  reqCnt, outId;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign stallNext[i] = (stallReg[i] | blockIn[i]) & ~unblockIn[i];
  end

  assign stalled = (|stallNext) | ctxSwitch;
  assign idMatch = (respId == outId);
  assign reqId   = cacheBlocked ? outId : reqCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallReg     <= '0;
      pcOut        <= RESET_PC;
      reqCnt       <= '0;
      outId        <= '0;
      cacheBlocked <= 1'b0;
    end else begin
      stallReg <= stallNext;
      if (strobe.loadCommitPc)      pcOut <= commitPc;
      else if (strobe.loadDecodePc) pcOut <= decodePc;
      if (strobe.issueNew) begin
        outId  <= reqCnt;
        reqCnt <= reqCnt + 1'b1;
      end
      if (strobe.parkRetry)       cacheBlocked <= 1'b1;
      else if (strobe.clearBlock) cacheBlocked <= 1'b0;
    end
  end

endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
  import fsc_pkg::*;
#(
  parameter int PCW      = 32,
  parameter int IDW      = 3,
  parameter int NSRC     = 4,
  parameter logic [PCW-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] blockIn,
  input  logic [NSRC-1:0] unblockIn,
  input  logic            ctxSwitch,
  input  logic            commitSquash,
  input  logic [PCW-1:0]  commitPc,
  input  logic            robSquashing,
  input  logic            decodeSquash,
  input  logic [PCW-1:0]  decodePc,
  input  logic            fetchAttempt,
  input  logic            faultIn,
  input  logic            reqReady,
  input  logic            respValid,
  input  logic [IDW-1:0]  respId,
  output logic [3:0]      status,
  output logic [PCW-1:0]  pcOut,
  output logic            reqValid,
  output logic [IDW-1:0]  reqId,
  output logic            dropResp,
  output logic            cacheBlocked
);

  fetchState_e state;
  fscStrobe_t  strobe;
  logic stalled, idMatch, respTake;

  fsc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .commitSquash(commitSquash), .robSquashing(robSquashing),
    .decodeSquash(decodeSquash), .stalled(stalled),
    .fetchAttempt(fetchAttempt), .faultIn(faultIn), .reqReady(reqReady),
    .respValid(respValid), .idMatch(idMatch),
    .state(state), .strobe(strobe), .reqValid(reqValid), .respTake(respTake)
  );

  fsc_datapath #(.PCW(PCW), .IDW(IDW), .NSRC(NSRC), .RESET_PC(RESET_PC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .blockIn(blockIn), .unblockIn(unblockIn), .ctxSwitch(ctxSwitch),
    .commitPc(commitPc), .decodePc(decodePc), .respId(respId),
    .stalled(stalled), .idMatch(idMatch), .pcOut(pcOut),
    .reqId(reqId), .cacheBlocked(cacheBlocked)
  );

  assign status   = state;
  assign dropResp = respValid & ~respTake;

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int PCW = 32
) (
  input logic           clk,
  input logic           rstN,
  input logic           commitSquash,
  input logic [PCW-1:0] commitPc,
  input logic           robSquashing,
  input logic           decodeSquash,
  input logic           respValid,
  input logic           dropResp,
  input logic [3:0]     status,
  input logic [PCW-1:0] pcOut,
  input logic           cacheBlocked
);

  logic anySquash;
  assign anySquash = commitSquash | robSquashing | decodeSquash;

  assert_status_legal_R1: assert property (@(posedge clk) disable iff (!rstN)
    status <= 4'd8);

  assert_commit_redirect_R3: assert property (@(posedge clk) disable iff (!rstN)
    commitSquash |=> (status == 4'd2) && (pcOut == $past(commitPc)));

  assert_decode_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (status == 4'd2 && decodeSquash && !commitSquash && !robSquashing) |=> $stable(pcOut));

  assert_wait_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (status == 4'd4 && !anySquash && !respValid) |=> status == 4'd4);

  assert_resp_taken_R8: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !dropResp) |=> (status == 4'd6 || status == 4'd3));

  assert_retry_blocks_R10: assert property (@(posedge clk) disable iff (!rstN)
    (status == 4'd5) |-> cacheBlocked);

  assert_trap_sticks_R11: assert property (@(posedge clk) disable iff (!rstN)
    (status == 4'd7 && !anySquash) |=> status == 4'd7);

  assert_squash_wins_R13: assert property (@(posedge clk) disable iff (!rstN)
    (anySquash && respValid) |-> dropResp);

endmodule

bind fetch_status_ctrl fsc_checker #(.PCW(PCW)) chk_i (
  .clk(clk), .rstN(rstN), .commitSquash(commitSquash), .commitPc(commitPc),
  .robSquashing(robSquashing), .decodeSquash(decodeSquash),
  .respValid(respValid), .dropResp(dropResp), .status(status),
  .pcOut(pcOut), .cacheBlocked(cacheBlocked)
);

// File: tb/fetch_status_ctrl_tb_top.sv
module fetch_status_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PCW = 32;
  localparam int IDW = 3;
  localparam int NSRC = 4;
  localparam logic [PCW-1:0] RST_PC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NSRC-1:0] blockIn = '0, unblockIn = '0;
  logic ctxSwitch = 0, commitSquash = 0, robSquashing = 0, decodeSquash = 0;
  logic [PCW-1:0] commitPc = '0, decodePc = '0;
  logic fetchAttempt = 0, faultIn = 0, reqReady = 0, respValid = 0;
  logic [IDW-1:0] respId = '0;
  logic [3:0] status;
  logic [PCW-1:0] pcOut;
  logic reqValid, dropResp, cacheBlocked;
  logic [IDW-1:0] reqId;

  int nChecks = 0, nFails = 0;
  int expId = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_status_ctrl #(.PCW(PCW), .IDW(IDW), .NSRC(NSRC), .RESET_PC(RST_PC)) dut_i (
    .clk(clk), .rstN(rstN), .blockIn(blockIn), .unblockIn(unblockIn),
    .ctxSwitch(ctxSwitch), .commitSquash(commitSquash), .commitPc(commitPc),
    .robSquashing(robSquashing), .decodeSquash(decodeSquash), .decodePc(decodePc),
    .fetchAttempt(fetchAttempt), .faultIn(faultIn), .reqReady(reqReady),
    .respValid(respValid), .respId(respId), .status(status), .pcOut(pcOut),
    .reqValid(reqValid), .reqId(reqId), .dropResp(dropResp), .cacheBlocked(cacheBlocked)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // advance one edge, then clear all single-cycle inputs
  task automatic tick();
    @(posedge clk); #2;
    blockIn = '0; unblockIn = '0; ctxSwitch = 0; commitSquash = 0;
    robSquashing = 0; decodeSquash = 0; fetchAttempt = 0; faultIn = 0;
    reqReady = 0; respValid = 0;
  endtask

  task automatic issueAccepted(input string tag);
    fetchAttempt = 1; reqReady = 1; #1;
    chk({tag, " R7 reqValid"}, reqValid, 1);
    chk({tag, " R7 reqId"}, reqId, expId[IDW-1:0]);
    expId++;
    tick();
    chk({tag, " R7 status"}, status, 4);
  endtask

  task automatic t_reset();
    chk("R1 status", status, 0);
    chk("R1 pc", pcOut, RST_PC);
    chk("R1 reqValid", reqValid, 0);
    chk("R1 cacheBlocked", cacheBlocked, 0);
  endtask

  task automatic t_hit();
    issueAccepted("hit");
    respValid = 1; respId = 3'(expId - 1); #1;
    chk("R8 no drop", dropResp, 0);
    tick();
    chk("R8 acc done", status, 6);
    fetchAttempt = 0; tick();
    chk("R8 holds without attempt", status, 6);
    fetchAttempt = 1; reqReady = 1; #1;
    chk("R8 no request from 6", reqValid, 0);
    tick();
    chk("R8 back to run", status, 0);
  endtask

  task automatic t_stall();
    blockIn = 4'b0010; tick();
    chk("R2 blocked", status, 3);
    tick();
    chk("R2 stays blocked", status, 3);
    unblockIn = 4'b0010; tick();
    chk("R2 unblock to run", status, 0);
    ctxSwitch = 1; tick();
    chk("R2 ctx switch blocks", status, 3);
    tick();
    chk("R2 ctx clear runs", status, 0);
  endtask

  task automatic t_waitStall();
    issueAccepted("waitStall");
    blockIn = 4'b0100; tick();
    chk("R6 wait ignores stall", status, 4);
    respValid = 1; respId = 3'(expId - 1); tick();
    chk("R8 stalled resp to blocked", status, 3);
    unblockIn = 4'b0100; tick();
    chk("R2 resume", status, 0);
  endtask

  task automatic t_stale();
    respValid = 1; respId = 3'd5; #1;
    chk("R9 drop in run", dropResp, 1);
    tick();
    chk("R9 status kept run", status, 0);
    issueAccepted("stale");
    respValid = 1; respId = 3'(expId + 2); #1;
    chk("R9 drop id mismatch", dropResp, 1);
    tick();
    chk("R9 still waiting", status, 4);
    respValid = 1; respId = 3'(expId - 1); tick();
    chk("R9 match after stale", status, 6);
    fetchAttempt = 1; tick();
  endtask

  task automatic t_retry();
    fetchAttempt = 1; reqReady = 0; #1;
    chk("R10 reqValid", reqValid, 1);
    chk("R10 reqId", reqId, expId[IDW-1:0]);
    expId++;
    tick();
    chk("R10 wait retry", status, 5);
    chk("R10 blocked flag", cacheBlocked, 1);
    #1;
    chk("R10 re-presented", reqValid, 1);
    chk("R10 same id", reqId, 3'(expId - 1));
    tick();
    chk("R10 still retry", status, 5);
    reqReady = 1; tick();
    chk("R10 accepted", status, 4);
    chk("R10 flag clear", cacheBlocked, 0);
    respValid = 1; respId = 3'(expId - 1); tick();
    chk("R10 response", status, 6);
    fetchAttempt = 1; tick();
  endtask

  task automatic t_commit();
    issueAccepted("commit");
    commitSquash = 1; commitPc = 32'h2000;
    decodeSquash = 1; decodePc = 32'h3000; tick();
    chk("R3 squashing", status, 2);
    chk("R3 commit target wins", pcOut, 32'h2000);
    tick();
    chk("R3 back to run", status, 0);
    respValid = 1; respId = 3'(expId - 1); #1;
    chk("R12 old response dropped", dropResp, 1);
    tick();
    chk("R12 status unchanged", status, 0);
  endtask

  task automatic t_retrySquash();
    fetchAttempt = 1; reqReady = 0; expId++; tick();
    chk("R12 parked", cacheBlocked, 1);
    commitSquash = 1; commitPc = 32'h2400; tick();
    chk("R12 retry cancelled", cacheBlocked, 0);
    chk("R12 squash state", status, 2);
    #1;
    chk("R12 no request", reqValid, 0);
    tick();
    chk("R12 run", status, 0);
  endtask

  task automatic t_robDecode();
    robSquashing = 1; tick();
    chk("R4 rob squash", status, 2);
    chk("R4 pc kept", pcOut, 32'h2400);
    decodeSquash = 1; decodePc = 32'h5000; tick();
    chk("R5 ignored pc", pcOut, 32'h2400);
    chk("R5 leaves squash", status, 0);
    decodeSquash = 1; decodePc = 32'h5000; tick();
    chk("R5 decode squash", status, 2);
    chk("R5 decode target", pcOut, 32'h5000);
    tick();
  endtask

  task automatic t_collide();
    issueAccepted("collide");
    commitSquash = 1; commitPc = 32'h6000;
    respValid = 1; respId = 3'(expId - 1); #1;
    chk("R13 response dropped", dropResp, 1);
    tick();
    chk("R13 squash wins", status, 2);
    chk("R13 pc", pcOut, 32'h6000);
    tick();
  endtask

  task automatic t_trap();
    fetchAttempt = 1; faultIn = 1; #1;
    chk("R11 no request on fault", reqValid, 0);
    tick();
    chk("R11 trap", status, 7);
    blockIn = 4'b1000; fetchAttempt = 1; tick();
    chk("R11 stall ignored", status, 7);
    unblockIn = 4'b1000; fetchAttempt = 1; tick();
    chk("R11 attempt ignored", status, 7);
    decodeSquash = 1; decodePc = 32'h7000; tick();
    chk("R11 redirect leaves trap", status, 2);
    chk("R11 pc", pcOut, 32'h7000);
    tick();
    chk("R11 run", status, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2; rstN = 1; #1;
    t_reset();
    t_hit();
    t_stall();
    t_waitStall();
    t_stale();
    t_retry();
    t_commit();
    t_retrySquash();
    t_robDecode();
    t_collide();
    t_trap();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule